// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address. It does this by fetching descriptors from a two-level table held in memory. A client raises a one-cycle request while the walker is idle. The walker then reads the first-level descriptor through a single-outstanding memory read port, and it reads a second-level descriptor only when the first one points to a lower table. When the walk ends, the walker pulses `done` for one cycle. With that pulse it gives either a physical address or a fault. It also shows the descriptors it fetched, so software-visible diagnosis can be built around it.

Three mapping granules are supported:

- 1 MiB sections, decoded straight from the first level.
- 64 KiB large pages, decoded from the second level.
- 4 KiB small pages, decoded from the second level.

Descriptor type is set by the two least significant bits of each descriptor. The memory port has a variable latency. The walker holds the read request and its address steady until a response strobe arrives.

Top module: `iova_walker`

## Requirements
- R1: A request seen while idle is accepted and starts a first-level read at address `tableBase + va[31:20]*4`. `memRdReq` and `memRdAddr` stay steady until `memRspValid` is seen.
- R2: A first-level descriptor with bits [1:0] = 2'b10 is a 1 MiB section. The result is `{desc[31:20], va[19:0]}` and no second read is made.
- R3: A first-level descriptor with bits [1:0] = 2'b01 points to a second-level table. Exactly one more read follows, at `{desc[31:10], va[19:12], 2'b00}`.
- R4: A second-level descriptor with bit 1 set is a 4 KiB small page. The result is `{desc[31:12], va[11:0]}`.
- R5: A second-level descriptor with bits [1:0] = 2'b01 is a 64 KiB large page. The result is `{desc[31:16], va[15:0]}`.
- R6: The walk ends in a fault in these cases, with one read for a first-level fault and two reads for a second-level fault:
  - a first-level descriptor with bits [1:0] of 2'b00 or 2'b11;
  - a second-level descriptor with bits [1:0] = 2'b00.
- R7: `done` is a single-cycle pulse in the cycle after the last read response. In that cycle exactly one of `paValid` and `fault` is high. Outside it, both are low.
- R8: `faultVa` takes the virtual address of a walk that faults when its `done` pulse appears. It keeps that value through later walks that succeed.
- R9: `busy` is high from the cycle after acceptance until the `done` cycle, and it is low in the `done` cycle. Requests raised while `busy` is high are ignored.
- R10: `l1Entry` shows the fetched first-level descriptor. `l2Entry` shows the second-level descriptor, or zero when the walk made no second read.
- R11: A `memRspValid` strobe that arrives while no read is outstanding has no effect.
- R12: After reset these outputs are all low or zero: `busy`, `done`, `memRdReq`, `paValid`, `fault`, `pa`, `faultVa`, `l1Entry` and `l2Entry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tableBase | input | 32 | Byte address of the first-level table |
| reqValid | input | 1 | Translation request, sampled while idle |
| reqVa | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| memRdReq | output | 1 | Read request, held until response |
| memRdAddr | output | 32 | Byte address of the descriptor to read |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 32 | Descriptor returned by memory |
| done | output | 1 | One-cycle completion pulse |
| paValid | output | 1 | Translation succeeded (with done) |
| pa | output | 32 | Translated physical address |
| fault | output | 1 | Translation fault (with done) |
| faultVa | output | 32 | Virtual address of the last faulting walk |
| l1Entry | output | 32 | First-level descriptor of the last walk |
| l2Entry | output | 32 | Second-level descriptor of the last walk, or zero |

## Verification
The bench builds the walker with its default 32-bit layout. With the 20/16/12-bit granule boundaries, the bench can reach the boundary cases directly: a section at the top index 0xFFF, and all four first-level codes with every second-level code. A sparse memory model answers with latencies of zero to three cycles. This exposes both the back-to-back response case and long waits in which the walker must hold its request steady and ignore a competing request or a stray response strobe.

// File: rtl/iova_walker_pkg.sv
`timescale 1ns/1ps
package iova_walker_pkg;
  localparam int VA_W      = 32;
  localparam int SECT_LSB  = 20;
  localparam int LARGE_LSB = 16;
  localparam int SMALL_LSB = 12;
  localparam int L2TBL_LSB = 10;
  localparam int L1_IDX_W  = VA_W - SECT_LSB;
  localparam int L2_IDX_W  = SECT_LSB - SMALL_LSB;

  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} walkState_e;

  typedef struct packed {
    logic accept;
    logic takeL1;
    logic takeL2;
  } walkStrobe_t;
endpackage

// File: rtl/iova_walker_ctrl.sv
`timescale 1ns/1ps
module iova_walker_ctrl
  import iova_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        l1IsPointer,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memRdReq
);
  walkState_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.accept = 1'b1;
        nextState     = ST_L1;
      end
      ST_L1: if (memRspValid) begin
        strobe.takeL1 = 1'b1;
        nextState     = l1IsPointer ? ST_L2 : ST_IDLE;
      end
      ST_L2: if (memRspValid) begin
        strobe.takeL2 = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy     = (state != ST_IDLE);
  assign memRdReq = (state == ST_L1) || (state == ST_L2);
endmodule

// File: rtl/iova_walker_dp.sv
`timescale 1ns/1ps
module iova_walker_dp
  import iova_walker_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  walkStrobe_t     strobe,
  input  logic [VA_W-1:0] tableBase,
  input  logic [VA_W-1:0] reqVa,
  input  logic [VA_W-1:0] memRspData,
  output logic            l1IsPointer,
  output logic [VA_W-1:0] memRdAddr,
  output logic            done,
  output logic            paValid,
  output logic [VA_W-1:0] pa,
  output logic            fault,
  output logic [VA_W-1:0] faultVa,
  output logic [VA_W-1:0] l1Entry,
  output logic [VA_W-1:0] l2Entry
);
  logic [VA_W-1:0] vaReg;
  logic [1:0]      code;
  logic            l1Section, l2Small, l2Large;
  logic [VA_W-1:0] l1Addr, l2Addr, sectPa, largePa, smallPa, hitPa;
  logic            finish, hitOk;

  assign code        = memRspData[1:0];
  assign l1IsPointer = (code == 2'b01);
  assign l1Section   = (code == 2'b10);
  assign l2Small     = memRspData[1];
  assign l2Large     = (code == 2'b01);

  // descriptor addresses: word-sized entries indexed by VA fields
  assign l1Addr = tableBase + {{(SECT_LSB-2){1'b0}}, reqVa[VA_W-1:SECT_LSB], 2'b00};
  assign l2Addr = {memRspData[VA_W-1:L2TBL_LSB], vaReg[SECT_LSB-1:SMALL_LSB], 2'b00};

  assign sectPa  = {memRspData[VA_W-1:SECT_LSB],  vaReg[SECT_LSB-1:0]};
  assign largePa = {memRspData[VA_W-1:LARGE_LSB], vaReg[LARGE_LSB-1:0]};
  assign smallPa = {memRspData[VA_W-1:SMALL_LSB], vaReg[SMALL_LSB-1:0]};

  always_comb begin
    finish = (strobe.takeL1 && !l1IsPointer) || strobe.takeL2;
    if (strobe.takeL1) begin
      hitOk = l1Section;
      hitPa = sectPa;
    end else begin
      hitOk = l2Small || l2Large;
      hitPa = l2Small ? smallPa : largePa;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      memRdAddr <= '0;
      done      <= 1'b0;
      paValid   <= 1'b0;
      fault     <= 1'b0;
      pa        <= '0;
      faultVa   <= '0;
      l1Entry   <= '0;
      l2Entry   <= '0;
    end else begin
      done    <= 1'b0;
      paValid <= 1'b0;
      fault   <= 1'b0;
      if (strobe.accept) begin
        vaReg     <= reqVa;
        memRdAddr <= l1Addr;
        l1Entry   <= '0;
        l2Entry   <= '0;
      end
      if (strobe.takeL1) begin
        l1Entry <= memRspData;
        if (l1IsPointer) memRdAddr <= l2Addr;
      end
      if (strobe.takeL2) l2Entry <= memRspData;
      if (finish) begin
        done    <= 1'b1;
        paValid <= hitOk;
        fault   <= !hitOk;
        if (hitOk) pa      <= hitPa;
        else       faultVa <= vaReg;
      end
    end
  end
endmodule

// File: rtl/iova_walker.sv
`timescale 1ns/1ps
module iova_walker
  import iova_walker_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [VA_W-1:0] tableBase,
  input  logic            reqValid,
  input  logic [VA_W-1:0] reqVa,
  output logic            busy,
  output logic            memRdReq,
  output logic [VA_W-1:0] memRdAddr,
  input  logic            memRspValid,
  input  logic [VA_W-1:0] memRspData,
  output logic            done,
  output logic            paValid,
  output logic [VA_W-1:0] pa,
  output logic            fault,
  output logic [VA_W-1:0] faultVa,
  output logic [VA_W-1:0] l1Entry,
  output logic [VA_W-1:0] l2Entry
);
  walkStrobe_t strobe;
  logic        l1IsPointer;

  iova_walker_ctrl ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .l1IsPointer(l1IsPointer), .strobe(strobe), .busy(busy), .memRdReq(memRdReq)
  );

  iova_walker_dp dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tableBase(tableBase), .reqVa(reqVa),
    .memRspData(memRspData), .l1IsPointer(l1IsPointer), .memRdAddr(memRdAddr),
    .done(done), .paValid(paValid), .pa(pa), .fault(fault), .faultVa(faultVa),
    .l1Entry(l1Entry), .l2Entry(l2Entry)
  );
endmodule

// File: rtl/iova_walker_chk.sv
`timescale 1ns/1ps
module iova_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        paValid,
  input logic        fault,
  input logic        memRdReq,
  input logic        memRspValid,
  input logic [31:0] memRdAddr,
  input logic [31:0] faultVa
);
  assert_read_held_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRspValid) |=> (memRdReq && $stable(memRdAddr)));

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (paValid ^ fault));

  assert_no_stray_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!paValid && !fault));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_faultva_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(faultVa) |-> (done && fault));

  assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));
endmodule

bind iova_walker iova_walker_chk chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .paValid(paValid),
  .fault(fault), .memRdReq(memRdReq), .memRspValid(memRspValid),
  .memRdAddr(memRdAddr), .faultVa(faultVa)
);

// File: tb/iova_walker_test.sv
`timescale 1ns/1ps
module iova_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] tableBase = 32'h0004_0000;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic        busy, memRdReq, done, paValid, fault;
  logic [31:0] memRdAddr, pa, faultVa, l1Entry, l2Entry;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  int latency = 0;
  int waitCnt = 0;
  int readCount = 0;
  bit responderOff = 1'b0;
  bit finished = 1'b0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] expAddrQ [$];
  string       expTagQ [$];

  iova_walker uut (
    .clk(clk), .rstN(rstN), .tableBase(tableBase), .reqValid(reqValid), .reqVa(reqVa),
    .busy(busy), .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .done(done), .paValid(paValid), .pa(pa), .fault(fault),
    .faultVa(faultVa), .l1Entry(l1Entry), .l2Entry(l2Entry)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      summary();
    end
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // memory responder with programmable latency
  always @(negedge clk) begin
    if (!responderOff) begin
      if (memRspValid) begin
        memRspValid = 1'b0;
        waitCnt = 0;
      end else if (memRdReq) begin
        if (waitCnt >= latency) begin
          logic [31:0] ea;
          string tg;
          ea = (expAddrQ.size() > 0) ? expAddrQ.pop_front() : 32'hFFFF_FFFF;
          tg = (expTagQ.size() > 0) ? expTagQ.pop_front() : "R6";
          check(memRdAddr == ea, tg, "read address", memRdAddr, ea);
          memRspData = rd(memRdAddr);
          memRspValid = 1'b1;
          readCount++;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  // behavioural reference of one walk, from the requirements
  task automatic refWalk(input logic [31:0] va, output bit ok, output logic [31:0] ePa,
                         output logic [31:0] e1, output logic [31:0] e2, output int reads);
    logic [31:0] a1, a2;
    a1 = tableBase + {18'h0, va[31:20], 2'b00};
    expAddrQ.push_back(a1); expTagQ.push_back("R1");
    e1 = rd(a1); e2 = 32'h0; reads = 1; ok = 1'b0; ePa = 32'h0;
    if (e1[1:0] == 2'b10) begin
      ok = 1'b1; ePa = {e1[31:20], va[19:0]};
    end else if (e1[1:0] == 2'b01) begin
      a2 = {e1[31:10], va[19:12], 2'b00};
      expAddrQ.push_back(a2); expTagQ.push_back("R3");
      e2 = rd(a2); reads = 2;
      if (e2[1]) begin ok = 1'b1; ePa = {e2[31:12], va[11:0]}; end
      else if (e2[1:0] == 2'b01) begin ok = 1'b1; ePa = {e2[31:16], va[15:0]}; end
    end
  endtask

  task automatic doWalk(input logic [31:0] va, input int lat, input bit poke, input string tag);
    bit ok; logic [31:0] ePa, e1, e2; int reads; int n;
    refWalk(va, ok, ePa, e1, e2, reads);
    latency = lat;
    readCount = 0;
    @(negedge clk); reqVa = va; reqValid = 1'b1;
    @(negedge clk); reqValid = 1'b0;
    n = 0;
    while (!done) begin
      check(busy == 1'b1, "R9", "busy during walk", {31'h0, busy}, 32'h1);
      if (poke && n == 0) begin reqValid = 1'b1; reqVa = va ^ 32'h8000_0000; end
      @(negedge clk); reqValid = 1'b0; n++;
    end
    check(busy == 1'b0, "R9", "busy at done", {31'h0, busy}, 32'h0);
    check(paValid == ok, tag, "paValid", {31'h0, paValid}, {31'h0, ok});
    check(fault == !ok, tag, "fault", {31'h0, fault}, {31'h0, !ok});
    if (ok) check(pa == ePa, tag, "pa", pa, ePa);
    else    check(faultVa == va, "R8", "faultVa", faultVa, va);
    check(readCount == reads, tag, "read count", readCount, reads);
    check(l1Entry == e1, "R10", "l1Entry", l1Entry, e1);
    check(l2Entry == e2, "R10", "l2Entry", l2Entry, e2);
    @(negedge clk);
    check(!done && !paValid && !fault, "R7", "pulse ends", {29'h0, done, paValid, fault}, 32'h0);
  endtask

  initial begin
    logic [31:0] keepVa, keepL1;
    // first level (base 0x40000)
    mem[32'h0004_0000 + 32'h123*4] = 32'hABC0_0002;  // section
    mem[32'h0004_0000 + 32'h004*4] = 32'h0010_0401;  // pointer to 0x00100400
    mem[32'h0004_0000 + 32'h200*4] = 32'h1234_5000;  // code 00
    mem[32'h0004_0000 + 32'h201*4] = 32'hFFFF_FFFF;  // code 11
    mem[32'h0004_0000 + 32'hFFF*4] = 32'hFFF0_0002;  // top section
    mem[32'h0004_0000 + 32'h005*4] = 32'h0020_0001;  // pointer, empty table
    // second level at 0x00100400
    mem[32'h0010_0400 + 32'h23*4] = 32'h7777_7002;   // small
    mem[32'h0010_0400 + 32'h59*4] = 32'h5555_0001;   // large
    mem[32'h0010_0400 + 32'h60*4] = 32'h8888_8003;   // small, code 11
    mem[32'h0010_0400 + 32'h24*4] = 32'h9999_9000;   // fault

    repeat (3) @(negedge clk);
    check(!busy && !done && !memRdReq && !paValid && !fault, "R12", "reset controls",
          {27'h0, busy, done, memRdReq, paValid, fault}, 32'h0);
    check((pa | faultVa | l1Entry | l2Entry) == 32'h0, "R12", "reset data",
          pa | faultVa | l1Entry | l2Entry, 32'h0);
    rstN = 1'b1;

    doWalk(32'h1230_5678, 0, 1'b0, "R2");
    doWalk(32'h0042_3ABC, 1, 1'b0, "R4");
    doWalk(32'h0045_9ABC, 2, 1'b0, "R5");
    doWalk(32'h0046_0123, 0, 1'b0, "R4");
    doWalk(32'hFFFF_FFFF, 3, 1'b0, "R2");
    doWalk(32'h2000_0010, 1, 1'b0, "R6");
    keepVa = 32'h2010_0020;
    doWalk(keepVa, 0, 1'b0, "R6");
    doWalk(32'h1231_0000, 2, 1'b0, "R2");
    check(faultVa == keepVa, "R8", "faultVa held after success", faultVa, keepVa);
    doWalk(32'h0042_4000, 3, 1'b0, "R6");
    doWalk(32'h0050_0000, 1, 1'b0, "R6");
    doWalk(32'h3330_0000, 0, 1'b0, "R6");
    doWalk(32'h0042_3ABC, 3, 1'b1, "R9");
    doWalk(32'h1234_5678, 0, 1'b1, "R9");

    // stray response while idle
    keepL1 = l1Entry;
    responderOff = 1'b1;
    @(negedge clk); memRspData = 32'hDEAD_BEE2; memRspValid = 1'b1;
    @(negedge clk); memRspValid = 1'b0;
    check(!done && !busy && !memRdReq, "R11", "stray strobe ignored",
          {29'h0, done, busy, memRdReq}, 32'h0);
    check(l1Entry == keepL1, "R11", "l1Entry unchanged", l1Entry, keepL1);
    @(negedge clk); responderOff = 1'b0;
    doWalk(32'h1230_0001, 1, 1'b0, "R2");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule